// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block holds the on-chip data storage and the special register space of a small 8-bit controller. A single request port carries an 8-bit address, an access mode and an operation. The block sends the request to one of four storage areas. These are the banked working registers, the bit-addressable RAM, the general RAM and a special register file. An optional upper RAM of 128 bytes can also be built in. Which area the upper half of the address space reaches depends on the access mode.

Byte reads and byte writes are supported. Single-bit operations are also supported: read, set, clear and write. Each bit change is a read-modify-write of the containing byte and takes one cycle. The working-register bank comes from a two-bit input, which the core drives from its status word. The special register at address D0H is the one the core uses for that status word.

Top module: `bank_dmem_ctrl`

## Requirements
- R1: After reset every storage byte reads 00H, `rdValid` is 0 and `rdData` is 00H.
- R2: Register mode (`mode`=0) reaches byte `bankSel`*8 + `addr[2:0]` of the low RAM. The upper address bits are ignored.
- R3: Direct mode (`mode`=1) and indirect mode (`mode`=2) to addresses 00H..7FH reach the same low RAM byte.
- R4: In bit mode (`mode`=3), a bit address below 80H selects bit `addr[2:0]` of low RAM byte 20H + `addr[6:3]`. So 00H is bit 0 of byte 20H and 7FH is bit 7 of byte 2FH.
- R5: A bit operation changes only the selected bit, in the same cycle, and leaves the other seven bits unchanged. `op`=2 sets the bit, `op`=3 clears it and `op`=1 copies `wrData[0]` into it.
- R6: In bit mode, a bit address of 80H or above selects bit `addr[2:0]` of the special register at address `addr` AND F8H.
- R7: For addresses 80H..FFH, direct mode reaches the special register file. Indirect mode reaches the upper RAM when `UPPER_EN`=1. The two are separate storage.
- R8: With `UPPER_EN`=0, an indirect read of 80H..FFH returns 00H and an indirect write there changes nothing.
- R9: Only special register addresses that are multiples of eight exist. A direct access to any other address from 80H up reads 00H and its write is ignored.
- R10: A read (`op`=0) returns its byte on `rdData`, with `rdValid` high, exactly one cycle after the request. In bit mode `rdBit` carries the selected bit. Other requests leave `rdValid` low.
- R11: Operation codes 2 and 3 in the byte modes (0, 1, 2) change no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one request per cycle |
| mode | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| op | input | 2 | 0 read, 1 write, 2 set bit, 3 clear bit |
| addr | input | 8 | Byte address, register number or bit address |
| wrData | input | 8 | Write byte; bit 0 is the value for a bit write |
| bankSel | input | 2 | Working-register bank from the status word |
| rdData | output | 8 | Registered read byte |
| rdBit | output | 1 | Registered selected bit for bit-mode reads |
| rdValid | output | 1 | High one cycle after a read request |

## Verification
The assertions assume that `mode`, `op` and `addr` are known whenever `reqValid` is high. They also assume that only one request arrives per cycle and that the read-modify-write finds the stored byte as the previous cycle left it. The bench drives every request on the falling edge, holds it for exactly one cycle and returns to idle. Each bit operation is therefore checked against a settled byte. Two instances, one with the upper RAM and one without, see the same stimulus. This lets the separation between indirect and direct access above 7FH be observed from both sides.

// File: rtl/bank_dmem_pkg.sv
package bank_dmem_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int HALF_BYTES  = 1 << (ADDR_W - 1);
  localparam int IDX_W       = ADDR_W - 1;
  localparam int BITPOS_W    = $clog2(DATA_W);
  localparam int SFR_COUNT   = HALF_BYTES / DATA_W;
  localparam int SFR_IDX_W   = $clog2(SFR_COUNT);
  localparam int BANK_W      = 2;
  localparam int REG_SEL_W   = 3;
  localparam logic [IDX_W-1:0] BIT_AREA_BASE = 7'h20;

  typedef enum logic [1:0] {
    MODE_REG = 2'd0, MODE_DIR = 2'd1, MODE_IND = 2'd2, MODE_BIT = 2'd3
  } accMode_e;

  typedef enum logic [1:0] {
    OP_READ = 2'd0, OP_WRITE = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3
  } accOp_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0, TGT_LOW = 2'd1, TGT_UPPER = 2'd2, TGT_SFR = 2'd3
  } target_e;

  typedef struct packed {
    target_e              target;
    logic [IDX_W-1:0]     index;
    logic [BITPOS_W-1:0]  bitPos;
    logic                 bitMode;
    logic                 wrEn;
    logic                 rdEn;
    logic                 newBit;
  } strobe_t;
endpackage

// File: rtl/bank_dmem_decode.sv
module bank_dmem_decode
  import bank_dmem_pkg::*;
#(
  parameter bit UPPER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  accMode_e          mode,
  input  accOp_e            op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrDataLsb,
  input  logic [BANK_W-1:0] bankSel,
  output strobe_t           strb
);
  logic highHalf;
  logic sfrAligned;

  assign highHalf   = addr[ADDR_W-1];
  assign sfrAligned = (addr[BITPOS_W-1:0] == '0);

  always_comb begin
    strb = '0;
    strb.bitPos = addr[BITPOS_W-1:0];
    unique case (mode)
      MODE_REG: begin
        strb.target = TGT_LOW;
        strb.index  = IDX_W'({bankSel, addr[REG_SEL_W-1:0]});
      end
      MODE_DIR: begin
        if (highHalf) begin
          strb.target = sfrAligned ? TGT_SFR : TGT_NONE;
          strb.index  = IDX_W'(addr[IDX_W-1:BITPOS_W]);
        end else begin
          strb.target = TGT_LOW;
          strb.index  = addr[IDX_W-1:0];
        end
      end
      MODE_IND: begin
        strb.target = highHalf ? (UPPER_EN ? TGT_UPPER : TGT_NONE) : TGT_LOW;
        strb.index  = addr[IDX_W-1:0];
      end
      default: begin
        strb.bitMode = 1'b1;
        if (highHalf) begin
          strb.target = TGT_SFR;
          strb.index  = IDX_W'(addr[IDX_W-1:BITPOS_W]);
        end else begin
          strb.target = TGT_LOW;
          strb.index  = BIT_AREA_BASE + IDX_W'(addr[IDX_W-1:BITPOS_W]);
        end
      end
    endcase
    strb.rdEn   = reqValid && (op == OP_READ);
    strb.wrEn   = reqValid && ((op == OP_WRITE) ||
                  ((mode == MODE_BIT) && ((op == OP_SET) || (op == OP_CLR))));
    strb.newBit = (op == OP_SET) ? 1'b1 : (op == OP_CLR) ? 1'b0 : wrDataLsb;
  end

  // Register-mode accesses never leave the 32-byte bank region.
  assert_bank_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == MODE_REG) |->
      (strb.target == TGT_LOW && strb.index < IDX_W'(32)));

  // Low bit addresses land inside the 16-byte bit area.
  assert_bit_area_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == MODE_BIT && !addr[ADDR_W-1]) |->
      (strb.index >= BIT_AREA_BASE && strb.index < BIT_AREA_BASE + IDX_W'(16)));
endmodule

// File: rtl/bank_dmem_store.sv
module bank_dmem_store
  import bank_dmem_pkg::*;
#(
  parameter bit UPPER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit,
  output logic              rdValid
);
  logic [DATA_W-1:0] lowRam  [HALF_BYTES];
  logic [DATA_W-1:0] sfrFile [SFR_COUNT];
  logic [DATA_W-1:0] upperRd;
  logic [DATA_W-1:0] curByte;
  logic [DATA_W-1:0] newByte;
  logic [DATA_W-1:0] bitMask;
  logic [SFR_IDX_W-1:0] sfrIdx;

  assign sfrIdx  = strb.index[SFR_IDX_W-1:0];
  assign bitMask = DATA_W'(1) << strb.bitPos;

  always_comb begin
    unique case (strb.target)
      TGT_LOW:   curByte = lowRam[strb.index];
      TGT_UPPER: curByte = upperRd;
      TGT_SFR:   curByte = sfrFile[sfrIdx];
      default:   curByte = '0;
    endcase
  end

  always_comb begin
    if (strb.bitMode)
      newByte = (curByte & ~bitMask) | (strb.newBit ? bitMask : '0);
    else
      newByte = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HALF_BYTES; i++) lowRam[i] <= '0;
    end else if (strb.wrEn && strb.target == TGT_LOW) begin
      lowRam[strb.index] <= newByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SFR_COUNT; i++) sfrFile[i] <= '0;
    end else if (strb.wrEn && strb.target == TGT_SFR) begin
      sfrFile[sfrIdx] <= newByte;
    end
  end

  generate
    if (UPPER_EN) begin : g_upper
      logic [DATA_W-1:0] upperRam [HALF_BYTES];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < HALF_BYTES; i++) upperRam[i] <= '0;
        end else if (strb.wrEn && strb.target == TGT_UPPER) begin
          upperRam[strb.index] <= newByte;
        end
      end
      assign upperRd = upperRam[strb.index];
    end else begin : g_noUpper
      assign upperRd = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdBit   <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) begin
        rdData <= curByte;
        rdBit  <= strb.bitMode ? curByte[strb.bitPos] : 1'b0;
      end
    end
  end

  // Checker state: remembers the last low-RAM bit operation.
  logic                chkLowBit;
  logic [IDX_W-1:0]    chkIdx;
  logic [DATA_W-1:0]   chkOld;
  logic [DATA_W-1:0]   chkMask;
  logic                chkVal;
  logic                chkNoneRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkLowBit <= 1'b0;
      chkIdx    <= '0;
      chkOld    <= '0;
      chkMask   <= '0;
      chkVal    <= 1'b0;
      chkNoneRd <= 1'b0;
    end else begin
      chkLowBit <= strb.wrEn && strb.bitMode && strb.target == TGT_LOW;
      chkIdx    <= strb.index;
      chkOld    <= curByte;
      chkMask   <= bitMask;
      chkVal    <= strb.newBit;
      chkNoneRd <= strb.rdEn && strb.target == TGT_NONE;
    end
  end

  assert_bit_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    chkLowBit |-> (((lowRam[chkIdx] & chkMask) != '0) == chkVal));

  assert_bit_neighbours_R5: assert property (@(posedge clk) disable iff (!rstN)
    chkLowBit |-> ((lowRam[chkIdx] & ~chkMask) == (chkOld & ~chkMask)));

  assert_absent_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    chkNoneRd |-> (rdData == '0 && rdValid));
endmodule

// File: rtl/bank_dmem_ctrl.sv
module bank_dmem_ctrl
  import bank_dmem_pkg::*;
#(
  parameter bit UPPER_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  mode,
  input  logic [1:0]  op,
  input  logic [7:0]  addr,
  input  logic [7:0]  wrData,
  input  logic [1:0]  bankSel,
  output logic [7:0]  rdData,
  output logic        rdBit,
  output logic        rdValid
);
  strobe_t strb;

  bank_dmem_decode #(.UPPER_EN(UPPER_EN)) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .mode      (accMode_e'(mode)),
    .op        (accOp_e'(op)),
    .addr      (addr),
    .wrDataLsb (wrData[0]),
    .bankSel   (bankSel),
    .strb      (strb)
  );

  bank_dmem_store #(.UPPER_EN(UPPER_EN)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdBit   (rdBit),
    .rdValid (rdValid)
  );

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && op == 2'd0) |=> rdValid);

  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && op == 2'd0) |=> !rdValid);
endmodule

// File: tb/bank_dmem_ctrl_tb.sv
module bank_dmem_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] mode = '0;
  logic [1:0] op = '0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] bankSel = '0;
  logic [7:0] rdData, rdDataNu;
  logic rdBit, rdBitNu, rdValid, rdValidNu;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_dmem_ctrl #(.UPPER_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .op(op),
    .addr(addr), .wrData(wrData), .bankSel(bankSel),
    .rdData(rdData), .rdBit(rdBit), .rdValid(rdValid));

  bank_dmem_ctrl #(.UPPER_EN(1'b0)) u_dutNoUp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .op(op),
    .addr(addr), .wrData(wrData), .bankSel(bankSel),
    .rdData(rdDataNu), .rdBit(rdBitNu), .rdValid(rdValidNu));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One request for one cycle; outputs sampled on the following falling edge.
  task automatic issue(input logic [1:0] m, input logic [1:0] o,
                       input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; mode = m; op = o; addr = a; wrData = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic rdByte(input string tag, input logic [1:0] m,
                        input logic [7:0] a, input logic [7:0] exp);
    issue(m, 2'd0, a, 8'h00);
    check({tag, " valid"}, rdValid, 1);
    check(tag, rdData, exp);
  endtask

  task automatic t_reset;
    check("R1 rdValid after reset", rdValid, 0);
    check("R1 rdData after reset", rdData, 0);
    rdByte("R1 low byte 30H", 2'd1, 8'h30, 8'h00);
    rdByte("R1 sfr D0H", 2'd1, 8'hD0, 8'h00);
    rdByte("R1 upper F0H", 2'd2, 8'hF0, 8'h00);
  endtask

  task automatic t_banks;
    for (int b = 0; b < 4; b++) begin
      bankSel = 2'(b);
      issue(2'd0, 2'd1, 8'hF8, 8'(8'hA0 + b * 8));      // register 0, high bits ignored
      issue(2'd0, 2'd1, 8'h07, 8'(8'hA7 + b * 8));
    end
    bankSel = 2'd0;
    for (int b = 0; b < 4; b++) begin
      rdByte("R2 bank reg0", 2'd1, 8'(b * 8), 8'(8'hA0 + b * 8));
      rdByte("R2 bank reg7", 2'd1, 8'(b * 8 + 7), 8'(8'hA7 + b * 8));
    end
    bankSel = 2'd2;
    rdByte("R2 register read bank2 r7", 2'd0, 8'h07, 8'hB7);
    bankSel = 2'd0;
  endtask

  task automatic t_dirInd;
    issue(2'd1, 2'd1, 8'h45, 8'h5A);
    rdByte("R3 indirect sees direct write", 2'd2, 8'h45, 8'h5A);
    issue(2'd2, 2'd1, 8'h7F, 8'hC3);
    rdByte("R3 direct sees indirect write", 2'd1, 8'h7F, 8'hC3);
  endtask

  task automatic t_bitLow;
    issue(2'd1, 2'd1, 8'h20, 8'h00);
    issue(2'd1, 2'd1, 8'h2F, 8'hFF);
    issue(2'd3, 2'd2, 8'h00, 8'h00);
    rdByte("R4 bit 00H is LSB of 20H", 2'd1, 8'h20, 8'h01);
    issue(2'd3, 2'd3, 8'h7F, 8'h00);
    rdByte("R4 bit 7FH is MSB of 2FH", 2'd1, 8'h2F, 8'h7F);
    issue(2'd3, 2'd0, 8'h7F, 8'h00);
    check("R10 rdBit of cleared 7FH", rdBit, 0);
    issue(2'd3, 2'd0, 8'h7E, 8'h00);
    check("R10 rdBit of 7EH", rdBit, 1);
    issue(2'd1, 2'd1, 8'h23, 8'hA5);
    issue(2'd3, 2'd2, 8'h1B, 8'h00);
    rdByte("R5 set bit3 of 23H", 2'd1, 8'h23, 8'hAD);
    issue(2'd3, 2'd3, 8'h18, 8'h00);
    rdByte("R5 clear bit0 of 23H", 2'd1, 8'h23, 8'hAC);
    issue(2'd3, 2'd1, 8'h1E, 8'hFF);
    rdByte("R5 write bit6 of 23H", 2'd1, 8'h23, 8'hEC);
    issue(2'd3, 2'd1, 8'h1F, 8'hFE);
    rdByte("R5 write 0 into bit7 of 23H", 2'd1, 8'h23, 8'h6C);
  endtask

  task automatic t_bitSfr;
    issue(2'd3, 2'd2, 8'hD3, 8'h00);
    rdByte("R6 bit D3H is bit3 of D0H", 2'd1, 8'hD0, 8'h08);
    issue(2'd3, 2'd2, 8'hE7, 8'h00);
    rdByte("R6 bit E7H is bit7 of E0H", 2'd1, 8'hE0, 8'h80);
    issue(2'd3, 2'd0, 8'hD3, 8'h00);
    check("R6 rdBit of D3H", rdBit, 1);
  endtask

  task automatic t_upper;
    issue(2'd1, 2'd1, 8'h90, 8'h11);
    issue(2'd2, 2'd1, 8'h90, 8'h22);
    rdByte("R7 direct 90H is special reg", 2'd1, 8'h90, 8'h11);
    rdByte("R7 indirect 90H is upper RAM", 2'd2, 8'h90, 8'h22);
    issue(2'd2, 2'd0, 8'h90, 8'h00);
    check("R8 no-upper indirect read valid", rdValidNu, 1);
    check("R8 no-upper indirect read zero", rdDataNu, 0);
    issue(2'd1, 2'd0, 8'h90, 8'h00);
    check("R8 no-upper write ignored, sfr kept", rdDataNu, 8'h11);
  endtask

  task automatic t_unimpl;
    issue(2'd1, 2'd1, 8'h81, 8'h77);
    rdByte("R9 unaligned 81H reads zero", 2'd1, 8'h81, 8'h00);
    rdByte("R9 write to 81H left 80H alone", 2'd1, 8'h80, 8'h00);
  endtask

  task automatic t_byteSet;
    issue(2'd1, 2'd2, 8'h45, 8'h00);
    issue(2'd1, 2'd3, 8'h7F, 8'h00);
    issue(2'd2, 2'd2, 8'h90, 8'h00);
    rdByte("R11 set op in direct mode no effect", 2'd1, 8'h45, 8'h5A);
    rdByte("R11 clear op in direct mode no effect", 2'd1, 8'h7F, 8'hC3);
    rdByte("R11 set op in indirect mode no effect", 2'd2, 8'h90, 8'h22);
  endtask

  task automatic t_latency;
    issue(2'd1, 2'd1, 8'h50, 8'h3C);
    check("R10 write gives no rdValid", rdValid, 0);
    issue(2'd1, 2'd0, 8'h50, 8'h00);
    check("R10 rdValid one cycle after read", rdValid, 1);
    check("R10 read data", rdData, 8'h3C);
    @(negedge clk);
    check("R10 rdValid drops", rdValid, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_banks();
    t_dirInd();
    t_bitLow();
    t_bitSfr();
    t_upper();
    t_unimpl();
    t_byteSet();
    t_latency();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule